// File: doc/BRIEF.md
# Acquisition Status Register with Sticky Interrupt Flag

This block is the byte-wide status word of an analog acquisition front end. The host reads it at a fixed bus offset, which is 8 by default. The byte reports four things: whether the converter is busy, the input polarity mode, how the input multiplexer is configured, and a latched interrupt flag. The low nibble holds a scan channel counter. That counter also drives the channel select of the multiplexer.

The interrupt flag is sticky. Once an interrupt event sets it, it stays set until the host writes any value to the register's offset. The channel counter steps once for each start of a conversion. It moves one clock after the edge that first samples the busy signal high, so the channel field only holds a settled value while the converter is idle. The counter wraps at 7 in differential mode and at 15 in single-ended mode. A conversion-start strobe returns the scan to channel 0.

Top module: `acq_status_reg`

## Requirements
- R1: While reset is asserted, and immediately after it is released, the channel counter is 0 and the interrupt flag is 0.
- R2: A read at the register offset returns this byte. Bits 3:0 hold the channel number, with bit 0 the least significant. Bit 4 is the interrupt flag. Bit 5 is the multiplexer mode (1 means sixteen single-ended inputs, 0 means eight differential inputs). Bit 6 is the polarity (1 means unipolar, 0 means bipolar). Bit 7 is the busy indication. Read data is combinational with the read strobe.
- R3: Bit 7 of the read byte equals the converter-busy input in the same cycle: 1 while busy, 0 while free.
- R4: An interrupt event sets the flag at the next clock edge. The flag then stays 1 through any number of cycles that have no clearing write.
- R5: A write strobe at the register offset clears the flag at the next clock edge, whatever the write data. A write at any other offset leaves the flag unchanged.
- R6: When an interrupt event and a clearing write fall in the same cycle, the flag is 1 afterwards.
- R7: For each rising edge of busy, the channel counter advances by exactly one. The step happens at the clock edge that follows the first edge sampling busy high. At no other time does the counter change, except through R9.
- R8: In differential mode the counter steps from 7 to 0. In single-ended mode it steps from 15 to 0. A value above 7 in differential mode also steps to 0.
- R9: A conversion-start strobe sets the channel counter to 0 at the next clock edge. It takes priority over a pending step.
- R10: When no read strobe is present, or the address differs from the register offset, the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convBusy | input | 1 | Converter busy level |
| convStart | input | 1 | Conversion-start strobe, restarts the scan at channel 0 |
| irqEvent | input | 1 | Interrupt event strobe |
| singleEnded | input | 1 | Mode strap: 1 for sixteen single-ended inputs, 0 for eight differential |
| unipolar | input | 1 | Mode strap: 1 for unipolar, 0 for bipolar |
| hostAddr | input | 4 | Host bus address |
| hostWr | input | 1 | Host write strobe (data is ignored) |
| hostRd | input | 1 | Host read strobe |
| hostRdData | output | 8 | Status byte on a read hit, else 0 |
| chanNum | output | 4 | Current multiplexer channel |

## Verification
Two pairs of functions can coincide in a single cycle. The first pair is an interrupt event and a clearing host write, which compete for the flag. The second pair is a conversion-start strobe and a pending channel step, which compete for the counter. Directed cycles drive each pair together, and random stimulus also lands on them by chance. Both results are read back through the status byte and the channel port. They are judged against a bench model in which set beats clear and restart beats step.

// File: rtl/acq_status_pkg.sv
package acq_status_pkg;

  localparam int STAT_W  = 8;
  localparam int CHAN_W  = 4;
  localparam int FLAG_BIT = 4;
  localparam int MUX_BIT  = 5;
  localparam int POL_BIT  = 6;
  localparam int BUSY_BIT = 7;

  typedef struct packed {
    logic incChan;
    logic restartChan;
    logic setFlag;
    logic clearFlag;
  } statStrobes_t;

endpackage

// File: rtl/acq_status_ctrl.sv
module acq_status_ctrl
  import acq_status_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convBusy,
  input  logic              convStart,
  input  logic              irqEvent,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  output statStrobes_t      strobes,
  output logic              readSel
);

  localparam logic [ADDR_W-1:0] OFFSET_ADDR = ADDR_W'(REG_OFFSET);

  logic regHit;
  logic busyQ;
  logic incPending;
  logic busyRise;

  assign regHit   = (hostAddr == OFFSET_ADDR);
  assign busyRise = convBusy & ~busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      incPending <= 1'b0;
    end else begin
      busyQ      <= convBusy;
      incPending <= busyRise;
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.incChan     = incPending;
    strobes.restartChan = convStart;
    strobes.setFlag     = irqEvent;
    strobes.clearFlag   = hostWr & regHit;
  end

  assign readSel = hostRd & regHit;

endmodule

// File: rtl/acq_status_dp.sv
module acq_status_dp
  import acq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  statStrobes_t      strobes,
  input  logic              convBusy,
  input  logic              singleEnded,
  input  logic              unipolar,
  input  logic              readSel,
  output logic [CHAN_W-1:0] chanNum,
  output logic              intFlag,
  output logic [STAT_W-1:0] rdData
);

  localparam logic [CHAN_W-1:0] LAST_SE   = '1;
  localparam logic [CHAN_W-1:0] LAST_DIFF = {1'b0, {(CHAN_W-1){1'b1}}};

  logic [CHAN_W-1:0] lastChan;
  logic [CHAN_W-1:0] chanNext;
  logic [STAT_W-1:0] statByte;

  assign lastChan = singleEnded ? LAST_SE : LAST_DIFF;

  always_comb begin
    chanNext = chanNum;
    if (strobes.restartChan) begin
      chanNext = '0;
    end else if (strobes.incChan) begin
      if (chanNum >= lastChan) chanNext = '0;
      else                     chanNext = chanNum + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanNum <= '0;
      intFlag <= 1'b0;
    end else begin
      chanNum <= chanNext;
      if (strobes.setFlag)        intFlag <= 1'b1;
      else if (strobes.clearFlag) intFlag <= 1'b0;
    end
  end

  always_comb begin
    statByte                 = '0;
    statByte[CHAN_W-1:0]     = chanNum;
    statByte[FLAG_BIT]       = intFlag;
    statByte[MUX_BIT]        = singleEnded;
    statByte[POL_BIT]        = unipolar;
    statByte[BUSY_BIT]       = convBusy;
  end

  assign rdData = readSel ? statByte : '0;

endmodule

// File: rtl/acq_status_reg.sv
module acq_status_reg
  import acq_status_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convBusy,
  input  logic              convStart,
  input  logic              irqEvent,
  input  logic              singleEnded,
  input  logic              unipolar,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  output logic [7:0]        hostRdData,
  output logic [3:0]        chanNum
);

  statStrobes_t strobes;
  logic         readSel;
  logic         intFlag;

  acq_status_ctrl #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .convBusy  (convBusy),
    .convStart (convStart),
    .irqEvent  (irqEvent),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostAddr  (hostAddr),
    .strobes   (strobes),
    .readSel   (readSel)
  );

  acq_status_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .convBusy    (convBusy),
    .singleEnded (singleEnded),
    .unipolar    (unipolar),
    .readSel     (readSel),
    .chanNum     (chanNum),
    .intFlag     (intFlag),
    .rdData      (hostRdData)
  );

endmodule

// File: rtl/acq_status_chk.sv
module acq_status_chk #(
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              convBusy,
  input logic              convStart,
  input logic              irqEvent,
  input logic              singleEnded,
  input logic              unipolar,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostWr,
  input logic              hostRd,
  input logic [7:0]        hostRdData,
  input logic [3:0]        chanNum,
  input logic              intFlag
);

  logic hit;
  logic busySeen;
  logic stepDue;

  assign hit = (hostAddr == ADDR_W'(REG_OFFSET));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busySeen <= 1'b0;
      stepDue  <= 1'b0;
    end else begin
      busySeen <= convBusy;
      stepDue  <= convBusy & ~busySeen;
    end
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (chanNum == 4'd0) && !intFlag);

  // R3
  a_r3_busy_bit: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hit) |-> (hostRdData[7] == convBusy));

  // R2
  a_r2_flag_bit: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hit) |-> (hostRdData[4] == intFlag) && (hostRdData[3:0] == chanNum));

  // R4
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    irqEvent |=> intFlag);

  // R4
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEvent && !(hostWr && hit)) |=> $stable(intFlag));

  // R5
  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hit && !irqEvent) |=> !intFlag);

  // R6
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hit && irqEvent) |=> intFlag);

  // R7
  a_r7_chan_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stepDue && !convStart) |=> $stable(chanNum));

  // R7
  a_r7_chan_step: assert property (@(posedge clk) disable iff (!rstN)
    (stepDue && !convStart) |=> (chanNum != $past(chanNum)));

  // R8
  a_r8_diff_range: assert property (@(posedge clk) disable iff (!rstN)
    (!singleEnded && stepDue && !convStart && chanNum >= 4'd7) |=> (chanNum == 4'd0));

  // R9
  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> (chanNum == 4'd0));

  // R10
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(hostRd && hit) |-> (hostRdData == 8'h00));

endmodule

bind acq_status_reg acq_status_chk #(
  .ADDR_W     (ADDR_W),
  .REG_OFFSET (REG_OFFSET)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .convBusy    (convBusy),
  .convStart   (convStart),
  .irqEvent    (irqEvent),
  .singleEnded (singleEnded),
  .unipolar    (unipolar),
  .hostAddr    (hostAddr),
  .hostWr      (hostWr),
  .hostRd      (hostRd),
  .hostRdData  (hostRdData),
  .chanNum     (chanNum),
  .intFlag     (intFlag)
);

// File: tb/acq_status_reg_tb.sv
module acq_status_reg_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convBusy = 1'b0;
  logic       convStart = 1'b0;
  logic       irqEvent = 1'b0;
  logic       singleEnded = 1'b0;
  logic       unipolar = 1'b0;
  logic [3:0] hostAddr = 4'd0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic [7:0] hostRdData;
  logic [3:0] chanNum;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [3:0] mChan = 4'd0;
  logic       mFlag = 1'b0;
  logic       mBusyQ = 1'b0;
  logic       mPend = 1'b0;

  always #4 clk = ~clk;

  acq_status_reg u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .convBusy    (convBusy),
    .convStart   (convStart),
    .irqEvent    (irqEvent),
    .singleEnded (singleEnded),
    .unipolar    (unipolar),
    .hostAddr    (hostAddr),
    .hostWr      (hostWr),
    .hostRd      (hostRd),
    .hostRdData  (hostRdData),
    .chanNum     (chanNum)
  );

  function automatic logic [7:0] expRead(logic rd, logic [3:0] a, logic b,
                                         logic u, logic s, logic f, logic [3:0] c);
    if (rd && a == 4'd8) return {b, u, s, f, c};
    return 8'h00;
  endfunction

  function automatic logic [3:0] nextChan(logic [3:0] c, logic se);
    logic [3:0] last;
    last = se ? 4'd15 : 4'd7;
    return (c >= last) ? 4'd0 : c + 4'd1;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s got 0x%0h exp 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input logic b, input logic cs, input logic irq,
                       input logic wr, input logic rd, input logic [3:0] a,
                       input string tag);
    @(negedge clk);
    convBusy = b; convStart = cs; irqEvent = irq;
    hostWr = wr; hostRd = rd; hostAddr = a;
    #1;
    check(tag, "chanNum", int'(chanNum), int'(mChan));
    check(tag, "rdData", int'(hostRdData),
          int'(expRead(rd, a, b, unipolar, singleEnded, mFlag, mChan)));
    if (rstN) begin
      if (cs)        mChan = 4'd0;
      else if (mPend) mChan = nextChan(mChan, singleEnded);
      mPend  = b & ~mBusyQ;
      mBusyQ = b;
      if (irq)                       mFlag = 1'b1;
      else if (wr && a == 4'd8)      mFlag = 1'b0;
    end
  endtask

  task automatic pulseBusy(input string tag);
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, tag);
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, tag);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, tag);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    // reset held: R1
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R1");
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R1");
    @(negedge clk); rstN = 1'b1;
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R1");

    // R2 layout with both straps set
    singleEnded = 1'b1; unipolar = 1'b1;
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R2");
    unipolar = 1'b0;
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R2");

    // R3 busy bit, R7 step one clock after rise
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R3");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R7");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R7");
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R3");

    // R4 set and sticky
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, "R4");
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R4");

    // R5 other-offset write ignored, then clearing write
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, "R5");
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R5");
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8, "R5");
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R5");

    // R6 set and clear together
    cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8, "R6");
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R6");

    // R10 no read / wrong address
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8, "R10");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9, "R10");
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R10");

    // R9 restart, including against a pending step
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8, "R9");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R9");
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8, "R9");
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8, "R9");

    // R8 wrap in differential then single-ended mode
    singleEnded = 1'b0;
    for (int i = 0; i < 10; i++) pulseBusy("R8");
    singleEnded = 1'b1;
    for (int i = 0; i < 18; i++) pulseBusy("R8");
    // R8 counter above 7 when switching to differential
    for (int i = 0; i < 10; i++) pulseBusy("R8");
    singleEnded = 1'b0;
    for (int i = 0; i < 3; i++) pulseBusy("R8");

    // random mix: R7 and all the rest through the model
    for (int i = 0; i < 3000; i++) begin
      logic b, cs, irq, wr, rd;
      logic [3:0] a;
      if (($urandom % 64) == 0) singleEnded = ~singleEnded;
      if (($urandom % 64) == 0) unipolar = ~unipolar;
      b   = (($urandom % 4) == 0) ? ~convBusy : convBusy;
      cs  = (($urandom % 40) == 0);
      irq = (($urandom % 12) == 0);
      wr  = (($urandom % 8) == 0);
      rd  = (($urandom % 2) == 0);
      a   = (($urandom % 3) == 0) ? 4'($urandom) : 4'd8;
      cycle(b, cs, irq, wr, rd, a, "R7");
    end

    summary();
  end

endmodule